// File: doc/BRIEF.md
# Processor State and Exception Entry Sequencer

This block holds the processing state of a 16-bit-bus core: normal, exception, halt or stopped. It also carries out the bus traffic that takes the core into an exception handler.

When an exception is accepted, the block does the following:
- It copies the live status word and program counter.
- It forces the supervisor bit on.
- It pushes a stack frame downward through the supervisor stack pointer, one 16-bit word per bus access.
- It reads the handler address from the vector table and hands control back to normal execution.

After reset the block reads the initial stack pointer and program counter itself. It then releases the core.

A bus error on one of the block's own accesses turns the running exception into a bus-error exception. A second bus error while a bus error is being handled is fatal, and the core locks in the halt state. The only way out of halt is an external reset. The block does not decode instructions and does not mask interrupt priority.

Top module: `proc_state_seq`

## Requirements
- R1: `procState` encodes the state as Normal=0, Exception=1, Halt=2, Stopped=3. While `rstN` is low the state is Exception. After `rstN` is released, the block issues four reads: 0 and 2 fill the stack pointer (high word, then low word), and 4 and 6 fill the program counter (high word, then low word). The state then becomes Normal with `srOut` = 0x2700.
- R2: After the frame is pushed, the handler address is read with two reads. The first is at vector×4 and gives the high word. The second is at vector×4+2 and gives the low word. Together they form `pcOut`, and the state then returns to Normal.
- R3: On the first cycle of an accepted exception, `srOut` equals the sampled `curSr` with bit 13 (supervisor) set. The unmodified `curSr` is the value that gets pushed.
- R4: Each frame word is written at `sspOut`−2, and `sspOut` drops by 2 per acknowledged write. The write order is: PC low, PC high, saved status, format word. The format word is {4'h0, 2'b00, vector, 2'b00}.
- R5: `stopReq` in Normal enters Stopped. In Stopped `busReq` stays low. An interrupt or trap request moves the state to Exception.
- R6: When several requests arrive in the same Normal cycle, they are taken in this order: bus error, then `irqReq` with `irqVec`, then `trapReq` with `trapVec`, then `stopReq`.
- R7: `busErr` asserted in Normal while the block is not on the bus (an error on the core's own access) starts an exception with vector 2.
- R8: A `busErr` on one of the block's accesses during a non-bus-error exception restarts the frame pushes with vector 2. The restart begins from the current stack pointer and keeps the saved PC and status word. A failed access does not decrement the stack pointer.
- R9: A `busErr` during a bus-error exception, or during the reset reads, enters Halt. In Halt no bus request is made and all requests are ignored until reset.
- R10: Requests raised while in Exception are dropped. They are not queued.
- R11: Every access of the block uses function code 3'b101 on `busFc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| irqReq | input | 1 | Interrupt request, one-cycle pulse |
| irqVec | input | 8 | Interrupt vector number |
| trapReq | input | 1 | Trap/trace request, one-cycle pulse |
| trapVec | input | 8 | Trap vector number |
| stopReq | input | 1 | STOP instruction executed |
| curPc | input | 32 | Current program counter of the core |
| curSr | input | 16 | Current status word of the core |
| busReq | output | 1 | Access request, held until ack or error |
| busWe | output | 1 | 1 = write |
| busFc | output | 3 | Function code of the access |
| busAddr | output | 32 | Byte address |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data |
| busAck | input | 1 | Access completed |
| busErr | input | 1 | Access failed, or the core's own access failed |
| procState | output | 2 | Processing state |
| pcOut | output | 32 | Program counter loaded by the block |
| srOut | output | 16 | Status word with supervisor bit forced |
| sspOut | output | 32 | Supervisor stack pointer |

## Verification
The bench raises interrupt, trap, stop and core-side bus error together, which shows whether the priority order holds; a wrong order would fetch the wrong vector. It injects an error into the second frame write. A design that decremented the stack pointer on the failed write, or that dropped the saved PC, would push the restarted frame at the wrong addresses. It also forces a second fault, first inside a bus-error exception and then during the reset reads. A design that let halt leak would keep issuing accesses or would return to Normal on a later interrupt. Finally, it drives requests during Stopped and Exception, where a design that queued them or touched the bus would show up as extra transactions in the scoreboard.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int AddrW   = 32;
  localparam int WordW   = 16;
  localparam int VecW    = 8;
  localparam int SBit    = 13;
  localparam int FcW     = 3;
  localparam logic [FcW-1:0]   FcSupData = 3'b101;
  localparam logic [VecW-1:0]  BerrVec   = 8'd2;
  localparam logic [WordW-1:0] ResetSr   = 16'h2700;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0, ST_EXCEPT = 2'd1, ST_HALT = 2'd2, ST_STOPPED = 2'd3
  } procState_e;

  typedef enum logic [3:0] {
    OP_NONE, OP_RST_SSPH, OP_RST_SSPL, OP_RST_PCH, OP_RST_PCL,
    OP_PUSH_PCL, OP_PUSH_PCH, OP_PUSH_SR, OP_PUSH_FMT, OP_VEC_H, OP_VEC_L
  } busOp_e;

  typedef struct packed {
    logic            capture;
    logic            wordDone;
    logic [VecW-1:0] vec;
    busOp_e          op;
  } dpCtl_t;
endpackage

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic [VecW-1:0] irqVec,
  input  logic            trapReq,
  input  logic [VecW-1:0] trapVec,
  input  logic            stopReq,
  input  logic            busAck,
  input  logic            busErr,
  output logic            busReq,
  output procState_e      state,
  output dpCtl_t          ctl
);
  busOp_e          op, nextOp;
  logic [VecW-1:0] vecR;
  logic            berrActive;
  logic            takeReq, takeBerr, stopNow, done, fault;
  logic [VecW-1:0] takeVec;

  assign busReq = (op != OP_NONE);
  assign done   = busReq && busAck && !busErr;
  assign fault  = busReq && busErr;

  always_comb begin
    takeReq  = 1'b0;
    takeBerr = 1'b0;
    takeVec  = '0;
    stopNow  = 1'b0;
    if (state == ST_NORMAL) begin
      if (busErr) begin
        takeReq = 1'b1; takeBerr = 1'b1; takeVec = BerrVec;
      end else if (irqReq) begin
        takeReq = 1'b1; takeVec = irqVec;
      end else if (trapReq) begin
        takeReq = 1'b1; takeVec = trapVec;
      end else if (stopReq) begin
        stopNow = 1'b1;
      end
    end else if (state == ST_STOPPED) begin
      if (irqReq) begin
        takeReq = 1'b1; takeVec = irqVec;
      end else if (trapReq) begin
        takeReq = 1'b1; takeVec = trapVec;
      end
    end
  end

  always_comb begin
    case (op)
      OP_RST_SSPH: nextOp = OP_RST_SSPL;
      OP_RST_SSPL: nextOp = OP_RST_PCH;
      OP_RST_PCH:  nextOp = OP_RST_PCL;
      OP_PUSH_PCL: nextOp = OP_PUSH_PCH;
      OP_PUSH_PCH: nextOp = OP_PUSH_SR;
      OP_PUSH_SR:  nextOp = OP_PUSH_FMT;
      OP_PUSH_FMT: nextOp = OP_VEC_H;
      OP_VEC_H:    nextOp = OP_VEC_L;
      default:     nextOp = OP_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_EXCEPT;
      op         <= OP_RST_SSPH;
      vecR       <= '0;
      berrActive <= 1'b1;
    end else begin
      case (state)
        ST_NORMAL, ST_STOPPED: begin
          if (takeReq) begin
            state      <= ST_EXCEPT;
            op         <= OP_PUSH_PCL;
            vecR       <= takeVec;
            berrActive <= takeBerr;
          end else if (stopNow) begin
            state <= ST_STOPPED;
          end
        end
        ST_EXCEPT: begin
          if (fault) begin
            if (berrActive) begin
              state <= ST_HALT;
              op    <= OP_NONE;
            end else begin
              vecR       <= BerrVec;
              berrActive <= 1'b1;
              op         <= OP_PUSH_PCL;
            end
          end else if (done) begin
            op <= nextOp;
            if (nextOp == OP_NONE) begin
              state      <= ST_NORMAL;
              berrActive <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign ctl.capture  = takeReq;
  assign ctl.wordDone = done;
  assign ctl.vec      = vecR;
  assign ctl.op       = op;

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_HALT |=> state == ST_HALT && !busReq);
  // R5
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_STOPPED |-> !busReq);
  // R10
  exc_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXCEPT && !busAck && !busErr) |=> (state == ST_EXCEPT && op == $past(op)));
  // R2
  vec_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_VEC_L && done) |=> state == ST_NORMAL && !busReq);
  // R1
  state_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> state == ST_EXCEPT);
endmodule

// File: rtl/psq_dpath.sv
module psq_dpath
  import psq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [AddrW-1:0] curPc,
  input  logic [WordW-1:0] curSr,
  input  logic [WordW-1:0] busRdata,
  output logic [AddrW-1:0] busAddr,
  output logic [WordW-1:0] busWdata,
  output logic             busWe,
  output logic [AddrW-1:0] pcOut,
  output logic [WordW-1:0] srOut,
  output logic [AddrW-1:0] sspOut
);
  localparam int HalfW = AddrW / 2;
  localparam logic [AddrW-1:0] Step = AddrW'(2);

  logic [AddrW-1:0] pcR, sspR, savedPc, vecAddr, pushAddr;
  logic [WordW-1:0] srR, savedSr, fmtWord;

  assign vecAddr  = {{(AddrW-VecW-2){1'b0}}, ctl.vec, 2'b00};
  assign pushAddr = sspR - Step;
  assign fmtWord  = {4'h0, 2'b00, ctl.vec, 2'b00};

  always_comb begin
    busWe    = 1'b0;
    busWdata = '0;
    case (ctl.op)
      OP_RST_SSPH: busAddr = AddrW'(0);
      OP_RST_SSPL: busAddr = AddrW'(2);
      OP_RST_PCH:  busAddr = AddrW'(4);
      OP_RST_PCL:  busAddr = AddrW'(6);
      OP_PUSH_PCL: begin busAddr = pushAddr; busWe = 1'b1; busWdata = savedPc[HalfW-1:0]; end
      OP_PUSH_PCH: begin busAddr = pushAddr; busWe = 1'b1; busWdata = savedPc[AddrW-1:HalfW]; end
      OP_PUSH_SR:  begin busAddr = pushAddr; busWe = 1'b1; busWdata = savedSr; end
      OP_PUSH_FMT: begin busAddr = pushAddr; busWe = 1'b1; busWdata = fmtWord; end
      OP_VEC_H:    busAddr = vecAddr;
      OP_VEC_L:    busAddr = vecAddr + Step;
      default:     busAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR     <= '0;
      sspR    <= '0;
      srR     <= ResetSr;
      savedPc <= '0;
      savedSr <= '0;
    end else begin
      if (ctl.capture) begin
        savedPc     <= curPc;
        savedSr     <= curSr;
        srR         <= curSr;
        srR[SBit]   <= 1'b1;
      end
      if (ctl.wordDone) begin
        case (ctl.op)
          OP_RST_SSPH: sspR[AddrW-1:HalfW] <= busRdata;
          OP_RST_SSPL: sspR[HalfW-1:0]     <= busRdata;
          OP_RST_PCH, OP_VEC_H: pcR[AddrW-1:HalfW] <= busRdata;
          OP_RST_PCL, OP_VEC_L: pcR[HalfW-1:0]     <= busRdata;
          OP_PUSH_PCL, OP_PUSH_PCH, OP_PUSH_SR, OP_PUSH_FMT: sspR <= pushAddr;
          default: ;
        endcase
      end
    end
  end

  assign pcOut  = pcR;
  assign srOut  = srR;
  assign sspOut = sspR;

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wordDone && busWe) |=> sspOut == $past(sspOut) - Step);
  // R3
  capture_sbit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> srOut[SBit] && savedSr == $past(curSr));
  // R8
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wordDone && !ctl.capture) |=> $stable(sspOut) && $stable(savedPc));
endmodule

// File: rtl/proc_state_seq.sv
module proc_state_seq
  import psq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [VecW-1:0]  irqVec,
  input  logic             trapReq,
  input  logic [VecW-1:0]  trapVec,
  input  logic             stopReq,
  input  logic [AddrW-1:0] curPc,
  input  logic [WordW-1:0] curSr,
  output logic             busReq,
  output logic             busWe,
  output logic [FcW-1:0]   busFc,
  output logic [AddrW-1:0] busAddr,
  output logic [WordW-1:0] busWdata,
  input  logic [WordW-1:0] busRdata,
  input  logic             busAck,
  input  logic             busErr,
  output logic [1:0]       procState,
  output logic [AddrW-1:0] pcOut,
  output logic [WordW-1:0] srOut,
  output logic [AddrW-1:0] sspOut
);
  dpCtl_t     ctl;
  procState_e state;

  psq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqVec(irqVec),
    .trapReq(trapReq), .trapVec(trapVec), .stopReq(stopReq),
    .busAck(busAck), .busErr(busErr), .busReq(busReq),
    .state(state), .ctl(ctl)
  );

  psq_dpath i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curPc(curPc), .curSr(curSr),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .pcOut(pcOut), .srOut(srOut), .sspOut(sspOut)
  );

  assign busFc     = busReq ? FcSupData : '0;
  assign procState = state;

  // R11
  fc_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busFc == 3'b101);
endmodule

// File: tb/test_proc_state_seq.sv
`timescale 1ns/1ps
module test_proc_state_seq;
  typedef struct { logic we; logic [31:0] addr; logic [15:0] data; } txn_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic irqReq = 0, trapReq = 0, stopReq = 0, coreErr = 0;
  logic [7:0] irqVec = 0, trapVec = 0;
  logic [31:0] curPc = 0;
  logic [15:0] curSr = 0, busRdata = 0, busWdata;
  logic busReq, busWe, busAck = 0, slvErr = 0, busErr;
  logic [2:0] busFc;
  logic [31:0] busAddr, pcOut, sspOut;
  logic [15:0] srOut;
  logic [1:0] procState;

  int vectors = 0, miscompares = 0, txnCount = 0, errAt = -1;
  logic [31:0] expSsp;
  txn_t expQ[$];

  always #2.5 clk = ~clk;
  assign busErr = slvErr | coreErr;

  proc_state_seq i_proc_state_seq (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqVec(irqVec),
    .trapReq(trapReq), .trapVec(trapVec), .stopReq(stopReq),
    .curPc(curPc), .curSr(curSr), .busReq(busReq), .busWe(busWe),
    .busFc(busFc), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck), .busErr(busErr),
    .procState(procState), .pcOut(pcOut), .srOut(srOut), .sspOut(sspOut)
  );

  function automatic logic [15:0] mem(input logic [31:0] a);
    return a[15:0] ^ 16'h3C00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: slave answers and pops the scoreboard
  always @(negedge clk) begin
    if (busAck || slvErr) begin
      busAck = 0; slvErr = 0;
    end else if (rstN && busReq) begin
      txn_t e;
      if (expQ.size() == 0) begin
        chk("R10 unexpected access", busAddr, 32'hFFFF_FFFF);
      end else begin
        e = expQ.pop_front();
        chk("R11 fc", {29'd0, busFc}, 32'd5);
        chk("R4 dir", {31'd0, busWe}, {31'd0, e.we});
        chk("R4 addr", busAddr, e.addr);
        if (e.we) chk("R4 data", {16'd0, busWdata}, {16'd0, e.data});
      end
      busRdata = mem(busAddr);
      if (txnCount == errAt) slvErr = 1; else busAck = 1;
      txnCount++;
    end
  end

  task automatic pushRd(input logic [31:0] a);
    expQ.push_back('{we: 1'b0, addr: a, data: 16'h0});
  endtask
  task automatic pushWr(input logic [31:0] a, input logic [15:0] d);
    expQ.push_back('{we: 1'b1, addr: a, data: d});
  endtask

  task automatic expEntry(input logic [7:0] v, input logic [15:0] sr, input logic [31:0] pc);
    pushWr(expSsp - 2, pc[15:0]);
    pushWr(expSsp - 4, pc[31:16]);
    pushWr(expSsp - 6, sr);
    pushWr(expSsp - 8, {6'd0, v, 2'b00});
    pushRd({22'd0, v, 2'b00});
    pushRd({22'd0, v, 2'b00} + 2);
    expSsp = expSsp - 8;
  endtask

  task automatic waitNormal();
    for (int i = 0; i < 200 && procState != 2'd0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic irq, input logic trap, input logic stp, input logic err);
    @(negedge clk);
    irqReq = irq; trapReq = trap; stopReq = stp; coreErr = err;
    @(negedge clk);
    irqReq = 0; trapReq = 0; stopReq = 0; coreErr = 0;
  endtask

  task automatic vecPc(input logic [7:0] v);
    chk("R2 pc", pcOut, {mem({22'd0, v, 2'b00}), mem({22'd0, v, 2'b00} + 2)});
    chk("R4 ssp", sspOut, expSsp);
    chk("R2 state", {30'd0, procState}, 32'd0);
    chk("R2 queue drained", expQ.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    chk("R1 state in reset", {30'd0, procState}, 32'd1);
    pushRd(0); pushRd(2); pushRd(4); pushRd(6);
    rstN = 1;
    waitNormal();
    expSsp = {mem(0), mem(2)};
    chk("R1 ssp", sspOut, expSsp);
    chk("R1 pc", pcOut, {mem(4), mem(6)});
    chk("R1 sr", {16'd0, srOut}, 32'h2700);
    chk("R1 queue drained", expQ.size(), 0);

    // R3/R2/R4 trap entry
    curPc = 32'h0001_2344; curSr = 16'h0004; trapVec = 8'h20;
    expEntry(8'h20, 16'h0004, 32'h0001_2344);
    pulse(0, 1, 0, 0);
    chk("R3 state", {30'd0, procState}, 32'd1);
    chk("R3 sr S set", {16'd0, srOut}, 32'h2004);
    waitNormal();
    vecPc(8'h20);

    // R6 priority irq over trap and stop
    curPc = 32'hABCD_0010; curSr = 16'h0710; irqVec = 8'h40; trapVec = 8'h21;
    expEntry(8'h40, 16'h0710, 32'hABCD_0010);
    pulse(1, 1, 1, 0);
    chk("R6 sr", {16'd0, srOut}, 32'h2710);
    waitNormal();
    vecPc(8'h40);

    // R7/R6 core bus error wins over irq
    curPc = 32'h0000_0F02; curSr = 16'h8000;
    expEntry(8'd2, 16'h8000, 32'h0000_0F02);
    pulse(1, 0, 0, 1);
    waitNormal();
    vecPc(8'd2);

    // R5 stop, quiet, leave on trap
    pulse(0, 0, 1, 0);
    chk("R5 stopped", {30'd0, procState}, 32'd3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R5 no access", {31'd0, busReq}, 32'd0);
    end
    curPc = 32'h0000_1000; curSr = 16'h0001; trapVec = 8'h25;
    expEntry(8'h25, 16'h0001, 32'h0000_1000);
    pulse(0, 1, 0, 0);
    chk("R5 exception", {30'd0, procState}, 32'd1);
    // R10 request during exception dropped
    pulse(1, 1, 0, 0);
    waitNormal();
    vecPc(8'h25);
    repeat (5) @(negedge clk);
    chk("R10 no late entry", {30'd0, procState}, 32'd0);

    // R8 fault on second push restarts as vector 2
    curPc = 32'h0055_AA00; curSr = 16'h0300; trapVec = 8'h30;
    errAt = txnCount + 1;
    pushWr(expSsp - 2, 16'hAA00);
    pushWr(expSsp - 4, 16'h0055);
    expSsp = expSsp - 2;
    expEntry(8'd2, 16'h0300, 32'h0055_AA00);
    pulse(0, 1, 0, 0);
    waitNormal();
    vecPc(8'd2);

    // R9 second bus error halts
    curPc = 32'h0000_2222; curSr = 16'h0000;
    errAt = txnCount + 2;
    pushWr(expSsp - 2, 16'h2222);
    pushWr(expSsp - 4, 16'h0000);
    pushWr(expSsp - 6, 16'h0000);
    pulse(0, 0, 0, 1);
    repeat (10) @(negedge clk);
    chk("R9 halted", {30'd0, procState}, 32'd2);
    pulse(1, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9 no access", {31'd0, busReq}, 32'd0);
    end
    chk("R9 still halted", {30'd0, procState}, 32'd2);
    chk("R9 queue drained", expQ.size(), 0);

    // R9 fault in reset reads halts
    rstN = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset leaves halt", {30'd0, procState}, 32'd1);
    errAt = txnCount;
    pushRd(0);
    rstN = 1;
    repeat (8) @(negedge clk);
    chk("R9 reset fault halts", {30'd0, procState}, 32'd2);
    chk("R9 reset queue", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule